// File: doc/BRIEF.md
# Nibble-Shared Constant Multiplier Bank

The bank takes one signed input sample per cycle and produces, in parallel, its product with each of eight run-time programmable coefficients. No general multiplier is used. Every coefficient magnitude is an 8-bit unsigned value that is split into two 4-bit digits, called alphabets. The first pipeline stage forms the sample times every one of the sixteen possible digit values, using only shifted copies of the sample and adders, and registers this table. The second stage builds each coefficient product from the table. It picks the entry for the upper digit, shifts it left by four, adds the entry for the lower digit, and negates the sum when the coefficient's sign bit is set.

Any number of slots that share a digit read the same table entry, so the cost of the products grows with the digit range and not with the number of coefficients. A surrounding FIR structure feeds samples in and owns the delay line and the accumulation across taps. Coefficients are loaded through a simple address, data and write-enable port at any time, including while samples are streaming.

Top module: `amb_alpha_mul_bank`

## Requirements
- R1: After reset, out_valid is low, every product field is zero and every coefficient slot holds sign 0 and magnitude 0, so a sample taken before any write yields zero in all slots.
- R2: A sample presented with in_valid high in cycle c produces out_valid high in cycle c+2 and in no other cycle. Back-to-back samples are accepted every cycle, and gaps in in_valid appear as gaps in out_valid.
- R3: Each slot's product equals the signed two's-complement sample (IN_W bits) times the slot's signed coefficient value, at full width OUT_W = IN_W+9 with no truncation, including the sample -2^(IN_W-1) times magnitude 255.
- R4: The magnitude's bits [7:4] form the upper digit and bits [3:0] the lower digit. Their table products combine as upper shifted left by 4 plus lower, so magnitudes 0x0F, 0xF0, 0x11 and 0xFF all give the exact product.
- R5: A sign bit of 1 negates the assembled magnitude product. A sign bit of 1 with magnitude 0 gives a product of zero.
- R6: When cw_en is high, the slot selected by cw_addr (0 to 7) stores {cw_sign, cw_mag} at the clock edge. All other slots keep their values.
- R7: A coefficient write presented in the same cycle as a sample applies to that sample. A write presented in the following cycle does not.
- R8: While out_valid is low, out_prod keeps the values of the last valid result.
- R9: The product for slot i sits at out_prod[i*OUT_W +: OUT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | IN_W | Signed input sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | $clog2(SLOTS) | Slot to write |
| cw_sign | input | 1 | Coefficient sign, 1 means negative |
| cw_mag | input | 8 | Unsigned coefficient magnitude |
| out_valid | output | 1 | Products valid strobe |
| out_prod | output | SLOTS*(IN_W+9) | Signed products, slot i at [i*OUT_W +: OUT_W] |

## Verification
The hardest case to reach is the race between the coefficient port and the pipeline. A write can land in the same cycle as a sample, or one cycle after it, while the earlier sample is still in the table stage. The stimulus places writes to the same slot in exactly those two positions around consecutive samples, and also interleaves random writes with a dense random sample stream. The extreme product, a most-negative sample against magnitude 255 with and without the sign bit, and a negative zero coefficient are driven directly.

// File: rtl/amb_pkg.sv
package amb_pkg;
    localparam int NIB_W   = 4;
    localparam int COEF_W  = 2 * NIB_W;
    localparam int ALPHA_N = 1 << NIB_W;

    typedef struct packed {
        logic              neg;
        logic [COEF_W-1:0] mag;
    } coef_t;

    localparam int CW = $bits(coef_t);

    function automatic int prod_width(input int in_w);
        return in_w + COEF_W + 1;
    endfunction

    function automatic int table_width(input int in_w);
        return in_w + NIB_W;
    endfunction
endpackage

// File: rtl/amb_coef_file.sv
module amb_coef_file
    import amb_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  coef_t               wr_data,
    output logic [SLOTS*CW-1:0] coef_flat
);
    coef_t slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= '0;
            else if (wr_en && (int'(wr_addr) == s))
                slot_q[s] <= wr_data;
        end
        assign coef_flat[s*CW +: CW] = slot_q[s];
    end
endmodule

// File: rtl/amb_alpha_pre.sv
module amb_alpha_pre
    import amb_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int PRE_W = table_width(IN_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [IN_W-1:0]          in_sample,
    output logic                     pre_valid,
    output logic [ALPHA_N*PRE_W-1:0] pre_flat
);
    logic signed [PRE_W-1:0] x_ext;
    assign x_ext = {{NIB_W{in_sample[IN_W-1]}}, in_sample};

    for (genvar k = 0; k < ALPHA_N; k++) begin : g_alpha
        logic signed [PRE_W-1:0] term;
        always_comb begin
            term = '0;
            for (int b = 0; b < NIB_W; b++) begin
                if (((k >> b) & 1) != 0)
                    term = term + (x_ext <<< b);
            end
        end
        always_ff @(posedge clk) begin
            if (rst)
                pre_flat[k*PRE_W +: PRE_W] <= '0;
            else if (in_valid)
                pre_flat[k*PRE_W +: PRE_W] <= term;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pre_valid <= 1'b0;
        else     pre_valid <= in_valid;
    end
endmodule

// File: rtl/amb_slot_build.sv
module amb_slot_build
    import amb_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int PRE_W = table_width(IN_W),
    parameter int OUT_W = prod_width(IN_W)
) (
    input  logic [ALPHA_N*PRE_W-1:0] pre_flat,
    input  coef_t                    coef,
    output logic [OUT_W-1:0]         prod
);
    logic [NIB_W-1:0]        hi_sel, lo_sel;
    logic [PRE_W-1:0]        hi_p, lo_p;
    logic signed [OUT_W-1:0] hi_x, lo_x, mag_p;

    assign hi_sel = coef.mag[COEF_W-1:NIB_W];
    assign lo_sel = coef.mag[NIB_W-1:0];
    assign hi_p   = pre_flat[int'(hi_sel)*PRE_W +: PRE_W];
    assign lo_p   = pre_flat[int'(lo_sel)*PRE_W +: PRE_W];
    assign hi_x   = {{(OUT_W-PRE_W){hi_p[PRE_W-1]}}, hi_p};
    assign lo_x   = {{(OUT_W-PRE_W){lo_p[PRE_W-1]}}, lo_p};
    assign mag_p  = (hi_x <<< NIB_W) + lo_x;
    assign prod   = coef.neg ? -mag_p : mag_p;
endmodule

// File: rtl/amb_alpha_mul_bank.sv
module amb_alpha_mul_bank
    import amb_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int SLOTS  = 8,
    parameter int ADDR_W = $clog2(SLOTS),
    parameter int PRE_W  = table_width(IN_W),
    parameter int OUT_W  = prod_width(IN_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [IN_W-1:0]        in_sample,
    input  logic                   cw_en,
    input  logic [ADDR_W-1:0]      cw_addr,
    input  logic                   cw_sign,
    input  logic [COEF_W-1:0]      cw_mag,
    output logic                   out_valid,
    output logic [SLOTS*OUT_W-1:0] out_prod
);
    logic [SLOTS*CW-1:0]      coef_flat;
    logic                     pre_valid;
    logic [ALPHA_N*PRE_W-1:0] pre_flat;
    logic [SLOTS*OUT_W-1:0]   build_flat;
    coef_t                    wr_word;

    assign wr_word = '{neg: cw_sign, mag: cw_mag};

    amb_coef_file #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_coef (
        .clk(clk), .rst(rst), .wr_en(cw_en), .wr_addr(cw_addr),
        .wr_data(wr_word), .coef_flat(coef_flat)
    );

    amb_alpha_pre #(.IN_W(IN_W), .PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .pre_valid(pre_valid), .pre_flat(pre_flat)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_build
        amb_slot_build #(.IN_W(IN_W), .PRE_W(PRE_W), .OUT_W(OUT_W)) u_build (
            .pre_flat(pre_flat),
            .coef(coef_t'(coef_flat[s*CW +: CW])),
            .prod(build_flat[s*OUT_W +: OUT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= pre_valid;
            if (pre_valid)
                out_prod <= build_flat;
        end
    end
endmodule

// File: rtl/amb_bank_checker.sv
module amb_bank_checker
    import amb_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int SLOTS  = 8,
    parameter int ADDR_W = $clog2(SLOTS),
    parameter int PRE_W  = table_width(IN_W),
    parameter int OUT_W  = prod_width(IN_W)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [IN_W-1:0]        in_sample,
    input logic                   cw_en,
    input logic [ADDR_W-1:0]      cw_addr,
    input logic                   cw_sign,
    input logic [COEF_W-1:0]      cw_mag,
    input logic                   mid_valid,
    input logic [PRE_W-1:0]       alpha_one,
    input logic [SLOTS*CW-1:0]    coef_flat,
    input logic                   out_valid,
    input logic [SLOTS*OUT_W-1:0] out_prod
);
    a_r2_stage_one: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> mid_valid);

    a_r2_stage_two: assert property (@(posedge clk) disable iff (rst)
        mid_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !mid_valid |=> !out_valid);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !mid_valid |=> $stable(out_prod));

    a_r3_unit_alphabet: assert property (@(posedge clk) disable iff (rst)
        mid_valid |-> ($signed(alpha_one) == $signed($past(in_sample))));

    a_r6_slot_store: assert property (@(posedge clk) disable iff (rst)
        cw_en |=> (coef_flat[int'($past(cw_addr))*CW +: CW] == $past({cw_sign, cw_mag})));
endmodule

bind amb_alpha_mul_bank amb_bank_checker #(
    .IN_W(IN_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_sign(cw_sign), .cw_mag(cw_mag),
    .mid_valid(pre_valid), .alpha_one(pre_flat[PRE_W +: PRE_W]),
    .coef_flat(coef_flat), .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/amb_alpha_mul_bank_bench.sv
module amb_alpha_mul_bank_bench;
    localparam int IN_W   = 12;
    localparam int SLOTS  = 8;
    localparam int ADDR_W = 3;
    localparam int OUT_W  = IN_W + 9;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   in_valid;
    logic [IN_W-1:0]        in_sample;
    logic                   cw_en;
    logic [ADDR_W-1:0]      cw_addr;
    logic                   cw_sign;
    logic [7:0]             cw_mag;
    logic                   out_valid;
    logic [SLOTS*OUT_W-1:0] out_prod;

    amb_alpha_mul_bank #(.IN_W(IN_W), .SLOTS(SLOTS)) u_amb_alpha_mul_bank (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_sign(cw_sign), .cw_mag(cw_mag),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    always #5 clk = ~clk;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     m_mag [SLOTS];
    bit     m_neg [SLOTS];
    longint e1 [SLOTS];
    longint e2 [SLOTS];
    bit     v1, v2;
    int     seed = 32'h1234_5678;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (out_valid !== v2) begin
            n_bad++;
            $display("FAIL %s out_valid: actual=%0b expected=%0b", tag, out_valid, v2);
        end
        for (int i = 0; i < SLOTS; i++) begin
            longint got;
            got = longint'($signed(out_prod[i*OUT_W +: OUT_W]));
            n_cmp++;
            if (got != e2[i]) begin
                n_bad++;
                $display("FAIL %s slot %0d product: actual=%0d expected=%0d", tag, i, got, e2[i]);
            end
        end
    endtask

    // One cycle: drive inputs, advance the reference at the edge, compare away from it.
    task automatic step(input bit v, input int smp, input bit we, input int addr,
                        input bit sg, input int mg, input string tag);
        in_valid  = v;
        in_sample = smp[IN_W-1:0];
        cw_en     = we;
        cw_addr   = addr[ADDR_W-1:0];
        cw_sign   = sg;
        cw_mag    = mg[7:0];
        @(posedge clk);
        if (we) begin
            m_mag[addr] = mg;
            m_neg[addr] = sg;
        end
        if (v1) e2 = e1;
        v2 = v1;
        v1 = v;
        if (v)
            for (int i = 0; i < SLOTS; i++)
                e1[i] = longint'(smp) * longint'(m_mag[i]) * (m_neg[i] ? -1 : 1);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h00FF_FFFF;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_sample = '0;
        cw_en = 0; cw_addr = '0; cw_sign = 0; cw_mag = '0;
        v1 = 0; v2 = 0;
        for (int i = 0; i < SLOTS; i++) begin
            m_mag[i] = 0; m_neg[i] = 0; e1[i] = 0; e2[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst = 1'b0;

        // R1: coefficients clear after reset
        step(1, 100, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");

        // R6: load every slot, one write per cycle
        step(0, 0, 1, 0, 0, 8'h01, "R6");
        step(0, 0, 1, 1, 0, 8'hFF, "R6");
        step(0, 0, 1, 2, 0, 8'hF0, "R6");
        step(0, 0, 1, 3, 0, 8'h0F, "R6");
        step(0, 0, 1, 4, 1, 8'h5A, "R6");
        step(0, 0, 1, 5, 1, 8'hFF, "R6");
        step(0, 0, 1, 6, 1, 8'h00, "R6");
        step(0, 0, 1, 7, 0, 8'h11, "R6");

        // R3 R4 R5 R9: back-to-back samples including full-scale extremes
        step(1, 0,     0, 0, 0, 0, "R3 R4 R9");
        step(1, 1,     0, 0, 0, 0, "R3 R4 R9");
        step(1, -1,    0, 0, 0, 0, "R3 R5 R9");
        step(1, 2047,  0, 0, 0, 0, "R3 R4 R9");
        step(1, -2048, 0, 0, 0, 0, "R3 R5 R9");
        step(1, 1234,  0, 0, 0, 0, "R4 R5 R9");
        step(1, -777,  0, 0, 0, 0, "R3 R5 R9");
        // R8 R2: idle cycles hold the last result
        step(0, 55, 0, 0, 0, 0, "R2 R8");
        step(0, 66, 0, 0, 0, 0, "R2 R8");
        step(0, 77, 0, 0, 0, 0, "R2 R8");

        // R2: sparse samples
        step(1, 321, 0, 0, 0, 0, "R2");
        step(0, 0,   0, 0, 0, 0, "R2");
        step(1, -5,  0, 0, 0, 0, "R2");
        step(0, 0,   0, 0, 0, 0, "R2");
        step(0, 0,   0, 0, 0, 0, "R2 R8");

        // R7: write in the same cycle applies, write one cycle later does not
        step(1, 500, 1, 2, 0, 3, "R7");
        step(1, 600, 0, 0, 0, 0, "R7");
        step(1, 300, 0, 0, 0, 0, "R7");
        step(0, 0,   1, 2, 1, 9, "R7");
        step(1, 300, 0, 0, 0, 0, "R7");
        step(0, 0,   0, 0, 0, 0, "R7");
        step(0, 0,   0, 0, 0, 0, "R7");

        // R3 R6 R8: random stream with interleaved writes
        for (int n = 0; n < 400; n++) begin
            int r1, r2;
            r1 = next_rand();
            r2 = next_rand();
            step(r1[0] | r1[1], (r1 >> 4) % 4096 - 2048, r2[0] & r2[1],
                 (r2 >> 2) & 7, r2[5], (r2 >> 8) & 255, "R3 R6 R8");
        end
        repeat (3) step(0, 0, 0, 0, 0, 0, "R8");
        summary();
    end
endmodule